// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block sits between the reset logic of a processor core and that core's memory bus. Once reset is released, it reads two consecutive 32-bit words from the base of the vector table. The first word is taken as the initial stack pointer value. The second word is the entry address for the program counter. Both values are then handed to the core, together with a one-cycle start strobe.

Both boot reads can be steered away from address zero to an alias base, set by a parameter. An input selects whether this remapping is applied. The block is built for a secondary core. Such a core must not begin fetching until software sets a release bit, which reaches the block as the `releaseEn` input.

The memory side is a simple read port. A request and its address are held until the memory grants them, and the data returns later with a valid flag. Only one read is in flight at any time.

Top module: `bootfetch_seq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `memReq`, `coreStart`, `spOut` and `pcOut` are all 0.
- R2: No read is requested while `releaseEn` is low. The first request appears in the cycle after a rising clock edge that samples `releaseEn` high.
- R3: The first boot read uses address ALIAS_BASE (default 0x00016000) when `remapEn` is 1, and address 0x0 when `remapEn` is 0.
- R4: The second boot read uses the first read's address plus 4: 0x00016004 when remapped, 0x4 when not.
- R5: `memReq` is held high with an unchanged `memAddr` until a clock edge at which `memGnt` is also high.
- R6: After a grant, `memReq` stays low until `memRvalid` returns the data. A `memRvalid` that arrives while no read is outstanding is ignored.
- R7: The first returned word is loaded into `spOut` unchanged, as a value and not as a pointer. Words are little-endian: `memRdata[7:0]` carries the byte at the lowest address. So the bytes f0 7e 80 1f produce `spOut` = 0x1f807ef0.
- R8: The second returned word is loaded into `pcOut` unchanged.
- R9: `coreStart` is high for exactly one cycle, the cycle after the second `memRvalid`. In that cycle `spOut` and `pcOut` already hold their final values. No further reads are issued until the next reset.
- R10: Asserting `rstN` low in any state stops the sequence, drops `memReq`, and clears `spOut`, `pcOut` and `coreStart`. The next release then runs the full two-read sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| releaseEn | input | 1 | Software release bit for the secondary core |
| remapEn | input | 1 | 1: boot reads use ALIAS_BASE; 0: boot reads use address 0 |
| memReq | output | 1 | Read request, held until granted |
| memAddr | output | ADDR_W | Byte address of the requested word |
| memGnt | input | 1 | Memory accepts the pending request |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | DATA_W | Read data, little-endian byte lanes |
| spOut | output | DATA_W | Initial stack pointer value |
| pcOut | output | DATA_W | Initial program counter value |
| coreStart | output | 1 | One-cycle pulse: core may begin execution |

## Verification
The testbench contains a reference model that runs cycle by cycle, and the outputs are compared against it on every clock. A wrong control state shows up on `memReq` or `memAddr` in the same cycle it goes wrong. Examples are a grant that is lost, a second request issued while a read is still outstanding, or a stray valid that is wrongly accepted. A word loaded into the wrong register, or a start strobe that is too long or misplaced, shows up on `spOut`, `pcOut` or `coreStart` one cycle after the returning `memRvalid`. The stimulus covers both states of `remapEn`, several grant and return latencies, stray valids, and a reset in the middle of a sequence.

// File: rtl/bootfetch_pkg.sv
package bootfetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_SP = 2'd1,
    ST_FETCH_PC = 2'd2,
    ST_DONE     = 2'd3
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic reqOn;      // drive a read request this cycle
    logic selPc;      // address the second vector word
    logic loadSp;     // capture read data as stack pointer
    logic loadPc;     // capture read data as program counter
    logic fireStart;  // raise coreStart on the next cycle
  } seqCtl_t;

endpackage

// File: rtl/bootfetch_ctrl.sv
module bootfetch_ctrl
  import bootfetch_pkg::*;
#(
  parameter bit IS_SECONDARY = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    releaseEn,
  input  logic    memGnt,
  input  logic    memRvalid,
  output seqCtl_t ctl
);

  seqState_t state, stateNext;
  logic      waitResp, waitRespNext;
  logic      goOk;

  assign goOk = !IS_SECONDARY || releaseEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitResp <= 1'b0;
    end else begin
      state    <= stateNext;
      waitResp <= waitRespNext;
    end
  end

  always_comb begin
    stateNext     = state;
    waitRespNext  = waitResp;
    ctl           = '0;
    unique case (state)
      ST_IDLE: begin
        if (goOk) stateNext = ST_FETCH_SP;
      end
      ST_FETCH_SP, ST_FETCH_PC: begin
        ctl.selPc = (state == ST_FETCH_PC);
        ctl.reqOn = !waitResp;
        if (!waitResp) begin
          if (memGnt) waitRespNext = 1'b1;
        end else if (memRvalid) begin
          waitRespNext = 1'b0;
          if (state == ST_FETCH_SP) begin
            ctl.loadSp = 1'b1;
            stateNext  = ST_FETCH_PC;
          end else begin
            ctl.loadPc    = 1'b1;
            ctl.fireStart = 1'b1;
            stateNext     = ST_DONE;
          end
        end
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // R6: no request while a read is outstanding
  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rstN)
    waitResp |-> !ctl.reqOn);

  // R2: a held secondary core stays idle
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (IS_SECONDARY && state == ST_IDLE && !releaseEn) |=> (state == ST_IDLE));

  // R9: sequence runs once per reset
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE && !ctl.reqOn));

  // R7/R8: the two loads never coincide
  assert_load_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadSp && ctl.loadPc));

endmodule

// File: rtl/bootfetch_dp.sv
module bootfetch_dp
  import bootfetch_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h0001_6000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              remapEn,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] pcOut,
  output logic              coreStart
);

  localparam int          WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] PC_OFFSET = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] tableBase;

  assign tableBase = remapEn ? ALIAS_BASE : '0;
  assign memAddr   = tableBase + (ctl.selPc ? PC_OFFSET : '0);
  assign memReq    = ctl.reqOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spOut     <= '0;
      pcOut     <= '0;
      coreStart <= 1'b0;
    end else begin
      if (ctl.loadSp) spOut <= memRdata;
      if (ctl.loadPc) pcOut <= memRdata;
      coreStart <= ctl.fireStart;
    end
  end

  // R9: start strobe lasts one cycle
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart);

  // R9: outputs stable once start has fired
  assert_values_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> ($stable(spOut) && $stable(pcOut)));

endmodule

// File: rtl/bootfetch_seq.sv
module bootfetch_seq
  import bootfetch_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 32'h0001_6000,
  parameter bit                IS_SECONDARY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              releaseEn,
  input  logic              remapEn,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] pcOut,
  output logic              coreStart
);

  seqCtl_t ctl;

  bootfetch_ctrl #(.IS_SECONDARY(IS_SECONDARY)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .releaseEn (releaseEn),
    .memGnt    (memGnt),
    .memRvalid (memRvalid),
    .ctl       (ctl)
  );

  bootfetch_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ALIAS_BASE (ALIAS_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .remapEn   (remapEn),
    .ctl       (ctl),
    .memRdata  (memRdata),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .spOut     (spOut),
    .pcOut     (pcOut),
    .coreStart (coreStart)
  );

  // R5: an ungranted request is held with the same address
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && ($stable(memAddr) || !$stable(remapEn))));

  // R6: after a grant the request drops
  assert_drop_after_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt) |=> !memReq);

endmodule

// File: tb/test_bootfetch_seq.sv
`timescale 1ns/1ps
module test_bootfetch_seq;

  localparam logic [31:0] ALIAS = 32'h0001_6000;

  logic clk = 1'b0, rstN = 1'b0, releaseEn = 1'b0, remapEn = 1'b1;
  logic memReq, memGnt = 1'b0, memRvalid = 1'b0, coreStart;
  logic [31:0] memAddr, memRdata = '0, spOut, pcOut;

  always #2.5 clk = ~clk;

  bootfetch_seq i_bootfetch_seq (
    .clk(clk), .rstN(rstN), .releaseEn(releaseEn), .remapEn(remapEn),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .memRvalid(memRvalid), .memRdata(memRdata),
    .spOut(spOut), .pcOut(pcOut), .coreStart(coreStart)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // memory contents as little-endian bytes
  function automatic logic [31:0] le(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction
  function automatic logic [31:0] wordAt(input logic [31:0] a);
    case (a)
      ALIAS:       return le(8'hf0, 8'h7e, 8'h80, 8'h1f);
      ALIAS + 4:   return le(8'h89, 8'hca, 8'h00, 8'h3f);
      32'h0:       return 32'h2000_1000;
      32'h4:       return 32'h0000_0401;
      default:     return 32'hbad0_bad0;
    endcase
  endfunction

  // ---------------- reference model ----------------
  int mPh = 0; bit mWait = 0, mStart = 0;
  logic [31:0] mSp = '0, mPc = '0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mWait = 0; mSp = '0; mPc = '0; mStart = 0;
    end else begin
      mStart = 0;
      if (mPh == 0) begin
        if (releaseEn) mPh = 1;
      end else if (mPh == 1 || mPh == 2) begin
        if (!mWait) begin
          if (memGnt) mWait = 1;
        end else if (memRvalid) begin
          mWait = 0;
          if (mPh == 1) begin mSp = memRdata; mPh = 2; end
          else begin mPc = memRdata; mStart = 1; mPh = 3; end
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (!finished) begin
      logic expReq;
      expReq = (mPh == 1 || mPh == 2) && !mWait;
      check("R5/R6 memReq", {31'b0, memReq}, {31'b0, expReq});
      if (expReq)
        check("R3/R4 memAddr", memAddr, (remapEn ? ALIAS : 32'h0) + (mPh == 2 ? 32'd4 : 32'd0));
      check("R7 spOut", spOut, mSp);
      check("R8 pcOut", pcOut, mPc);
      check("R9 coreStart", {31'b0, coreStart}, {31'b0, mStart});
    end
  end

  // ---------------- memory responder ----------------
  int gntLat = 0, rvLat = 0, rs = 0, cnt = 0;
  bit stray = 0;
  logic [31:0] heldAddr = '0;
  always @(negedge clk) begin
    memGnt = 1'b0; memRvalid = 1'b0;
    if (!rstN) begin
      rs = 0; cnt = 0;
    end else if (rs == 0) begin
      if (memReq) begin
        if (cnt >= gntLat) begin
          memGnt = 1'b1; heldAddr = memAddr; rs = 1; cnt = 0;
        end else cnt++;
      end else if (stray) begin
        memRvalid = 1'b1; memRdata = 32'hdead_beef;
      end
    end else begin
      if (cnt >= rvLat) begin
        memRvalid = 1'b1; memRdata = wordAt(heldAddr); rs = 0; cnt = 0;
      end else cnt++;
    end
  end

  task automatic waitStart(input string req);
    int n = 0;
    do begin @(negedge clk); #2; n++; end while (!coreStart && n < 200);
    total++;
    if (!coreStart) begin
      bad++; $display("FAIL %s: actual=0 expected=1 (coreStart timeout)", req);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; releaseEn = 1'b0;
    repeat (2) @(negedge clk);
    #2; check("R1 reset memReq", {31'b0, memReq}, 32'd0);
    check("R1 reset spOut", spOut, 32'd0);
    check("R1 reset pcOut", pcOut, 32'd0);
    check("R1 reset coreStart", {31'b0, coreStart}, 32'd0);
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1, R2: reset and held secondary core
    remapEn = 1'b1; gntLat = 2; rvLat = 1;
    doReset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #2; check("R2 held no memReq", {31'b0, memReq}, 32'd0);
    end
    // remapped run, little-endian stack pointer
    @(negedge clk); releaseEn = 1'b1;
    @(negedge clk); #2; check("R2 request after release", {31'b0, memReq}, 32'd1);
    check("R3 alias address", memAddr, 32'h0001_6000);
    waitStart("R9 remapped");
    check("R7 little-endian sp", spOut, 32'h1f80_7ef0);
    check("R8 entry pc", pcOut, 32'h3f00_ca89);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #2; check("R9 no further reads", {31'b0, memReq}, 32'd0);
    end

    // unremapped run, zero latency, stray valids
    remapEn = 1'b0; gntLat = 0; rvLat = 0; stray = 1;
    doReset();
    releaseEn = 1'b1;
    @(negedge clk); #2; check("R3 plain address", memAddr, 32'h0);
    waitStart("R9 plain");
    check("R7 plain sp", spOut, 32'h2000_1000);
    check("R8 plain pc", pcOut, 32'h0000_0401);
    stray = 0;

    // R10: reset during second read, then rerun
    remapEn = 1'b1; gntLat = 1; rvLat = 4;
    doReset();
    releaseEn = 1'b1;
    do begin @(negedge clk); #2; end while (!(memReq && memAddr == ALIAS + 4));
    check("R4 second address", memAddr, 32'h0001_6004);
    rstN = 1'b0; releaseEn = 1'b0;
    #1; check("R10 memReq cleared", {31'b0, memReq}, 32'd0);
    check("R10 spOut cleared", spOut, 32'd0);
    check("R10 coreStart cleared", {31'b0, coreStart}, 32'd0);
    @(negedge clk); @(negedge clk); rstN = 1'b1; releaseEn = 1'b1;
    gntLat = 3; rvLat = 3; stray = 1;
    waitStart("R10 rerun");
    check("R10 rerun sp", spOut, 32'h1f80_7ef0);
    check("R10 rerun pc", pcOut, 32'h3f00_ca89);
    repeat (4) @(negedge clk);
    #2;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule